// File: doc/BRIEF.md
# Cascadable Four-Channel Countdown Timer Group

This block holds four down-counting timers that share one prescaled tick and sit behind a small word-addressed register port. Each timer reloads from its own base value every time it runs out and raises a one-cycle interrupt pulse. As long as it is allowed to run, it keeps producing interrupts at a fixed period. A single group control word sets the prescale divisor that all four timers share. The same word can also link a timer to the one above it, so that together they form one longer counter.

Software loads a timer by writing its base word with the hold flag set. That write also presets the live count. Software then writes the base word again with the hold flag clear, and counting begins from the loaded value. In a linked pair, the lower timer counts prescaled ticks. The upper timer counts once each time the lower timer wraps. Only the upper timer signals the pair's expiry, and the upper timer's hold flag starts and stops both timers.

Top module: `tmr_group`

## Requirements
- R1: After reset, every base word reads 0x8000_0000 (hold flag set, value 0), every count word, routing word and group control word reads 0, and all interrupt outputs are low.
- R2: Timer n occupies addresses n*0x40 to n*0x40+0x3F. Within that window, offset 0x00 is the count word, 0x10 the base word, 0x20 the routing word and 0x30 the destination word. The last two are plain 32-bit storage. The group control word is at 0x100. Any other address reads 0, and a write to it has no effect.
- R3: The shared tick fires once every 8 × 2^S clocks, where S is group control bits 9:8 (S = 0 divides by 8, S = 3 by 64). A free-running timer advances once per tick.
- R4: While the hold flag (base bit 31) of a timer, or of the top of its linked chain, is set, its count word does not change except through register writes.
- R5: A base write loads bits 30:0 of the written value into the count field when the hold flag was set before the write or is set in the written value. The toggle bit is left unchanged.
- R6: When a running timer advances while its count field is 0 or 1, it reloads the count from base bits 30:0 and inverts the toggle bit (count word bit 31). Its interrupt is high for exactly the next clock cycle. At any other count it decrements by one, so the interrupt period is base × tick period.
- R7: A count word write sets the count field from bits 30:0 and the toggle bit from bit 31 of the written value.
- R8: When group control bit i (i = 0..2) is set, timer i+1 advances only in the cycle where timer i expires. Timer i never raises its interrupt. Timer i runs or holds according to the hold flag of the highest timer in its linked chain.
- R9: The group control word keeps bits 2:0 (links), 9:8 (divisor) and 26:24 (rollover, plain storage) and reads 0 in every other bit.
- R10: A register write to a timer in the same cycle as that timer advances takes precedence over the count update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 9 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| tmr_irq | output | 4 | One-cycle expiry pulse per timer |

## Verification
A single free-running timer is tried at the two ends of the divisor range. Counting its pulses over fixed windows exposes a wrong divisor decode or an off-by-one in the reload period. A linked pair whose lower half has its hold flag clear shows whether the chain top really governs the lower timer, and whether the lower timer's pulse is masked. Rapid count writes against a running timer at the fastest divisor force a write and an advance into the same cycle, which separates write precedence from step precedence. Throughout, a behavioural model compares every interrupt line and every read word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = DATA_W - 1;

  // number of clocks between shared ticks for a given divisor select
  function automatic int unsigned tick_period(input int unsigned base_log2,
                                              input int unsigned sel);
    return 32'd1 << (base_log2 + sel);
  endfunction

  // a step taken at this count ends the period
  function automatic logic at_terminal(input logic [CNT_W-1:0] cnt);
    return cnt <= CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] count_dec(input logic [CNT_W-1:0] cnt);
    return cnt - CNT_W'(1);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned BASE_LOG2 = 3,
  parameter int unsigned SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned PW = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;

  always_comb begin
    lim  = PW'(tmr_pkg::tick_period(BASE_LOG2, 32'(sel)) - 1);
    // >= so that shrinking the divisor mid-count never stalls the tick
    tick = (cnt_q >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              expire,
  input  logic              irq_mask,
  input  logic              wr_cnt,
  input  logic              wr_base,
  input  logic              wr_vec,
  input  logic              wr_dst,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_reg,
  output logic [DATA_W-1:0] base_reg,
  output logic [DATA_W-1:0] vec_reg,
  output logic [DATA_W-1:0] dst_reg,
  output logic              hold,
  output logic              irq
);
  logic [CNT_W-1:0]  cnt_q;
  logic              tog_q;
  logic [DATA_W-1:0] base_q;
  logic [DATA_W-1:0] vec_q;
  logic [DATA_W-1:0] dst_q;
  logic              irq_q;
  logic              preset;

  assign preset   = wr_base & (base_q[DATA_W-1] | wdata[DATA_W-1]);
  assign cnt_reg  = {tog_q, cnt_q};
  assign base_reg = base_q;
  assign vec_reg  = vec_q;
  assign dst_reg  = dst_q;
  assign hold     = base_q[DATA_W-1];
  assign irq      = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tog_q  <= 1'b0;
      base_q <= {1'b1, {CNT_W{1'b0}}};
      vec_q  <= '0;
      dst_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= expire & ~irq_mask;
      if (wr_cnt) begin
        tog_q <= wdata[DATA_W-1];
        cnt_q <= wdata[CNT_W-1:0];
      end else begin
        if (expire) begin
          cnt_q <= base_q[CNT_W-1:0];
          tog_q <= ~tog_q;
        end else if (step) begin
          cnt_q <= count_dec(cnt_q);
        end
        if (preset) cnt_q <= wdata[CNT_W-1:0];
      end
      if (wr_base) base_q <= wdata;
      if (wr_vec)  vec_q  <= wdata;
      if (wr_dst)  dst_q  <= wdata;
    end
  end
endmodule

// File: rtl/tmr_group.sv
module tmr_group
  import tmr_pkg::*;
#(
  parameter int unsigned N_TMR     = 4,
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned PRE_LOG2  = 3,
  parameter int unsigned SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_TMR-1:0]  tmr_irq
);
  localparam int unsigned LINK_W   = N_TMR - 1;
  localparam int unsigned TSEL_W   = $clog2(N_TMR);
  localparam int unsigned SLOT_LOG = 4;
  localparam int unsigned WIN_LSB  = SLOT_LOG + 2;
  localparam int unsigned DSEL_LSB = 8;
  localparam int unsigned ROLL_LSB = 24;
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(N_TMR << WIN_LSB);

  // group control state
  logic [LINK_W-1:0] link_q;
  logic [LINK_W-1:0] roll_q;
  logic [SEL_W-1:0]  dsel_q;

  // decode
  logic              ctl_hit;
  logic              win_hit;
  logic [TSEL_W-1:0] tsel;
  logic [1:0]        rsel;

  assign ctl_hit = (bus_addr == CTL_ADDR);
  assign win_hit = ((bus_addr >> (WIN_LSB + TSEL_W)) == '0) &&
                   (bus_addr[SLOT_LOG-1:0] == '0);
  assign tsel    = bus_addr[WIN_LSB +: TSEL_W];
  assign rsel    = bus_addr[WIN_LSB-1:SLOT_LOG];

  // per-timer internal events
  logic                         tick;
  logic [N_TMR-1:0]             run;
  logic [N_TMR-1:0]             step;
  logic [N_TMR-1:0]             expire;
  logic [N_TMR-1:0]             hold;
  logic [N_TMR-1:0]             link_in;
  logic [N_TMR-1:0]             link_out;
  logic [N_TMR-1:0]             wr_cnt;
  logic [N_TMR-1:0]             wr_base;
  logic [N_TMR-1:0]             wr_vec;
  logic [N_TMR-1:0]             wr_dst;
  logic [N_TMR-1:0][CNT_W-1:0]  cnt_w;
  logic [DATA_W-1:0]            cnt_reg  [N_TMR];
  logic [DATA_W-1:0]            base_reg [N_TMR];
  logic [DATA_W-1:0]            vec_reg  [N_TMR];
  logic [DATA_W-1:0]            dst_reg  [N_TMR];

  assign link_in  = {link_q, 1'b0};   // timer i is the upper half of a pair
  assign link_out = {1'b0, link_q};   // timer i is the lower half of a pair

  tmr_prescaler #(.BASE_LOG2(PRE_LOG2), .SEL_W(SEL_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (dsel_q),
    .tick (tick)
  );

  // run enable comes down from the top of each linked chain
  always_comb begin
    run = '0;
    run[N_TMR-1] = ~hold[N_TMR-1];
    for (int i = N_TMR - 2; i >= 0; i--) begin
      run[i] = link_q[i] ? run[i+1] : ~hold[i];
    end
  end

  // advance and expiry ripple upward through the links
  always_comb begin
    logic carry;
    carry  = 1'b0;
    step   = '0;
    expire = '0;
    for (int i = 0; i < N_TMR; i++) begin
      step[i]   = run[i] & (link_in[i] ? carry : tick);
      expire[i] = step[i] & at_terminal(cnt_w[i]);
      carry     = expire[i];
    end
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    assign wr_cnt[g]  = bus_wr & win_hit & (tsel == TSEL_W'(g)) & (rsel == 2'd0);
    assign wr_base[g] = bus_wr & win_hit & (tsel == TSEL_W'(g)) & (rsel == 2'd1);
    assign wr_vec[g]  = bus_wr & win_hit & (tsel == TSEL_W'(g)) & (rsel == 2'd2);
    assign wr_dst[g]  = bus_wr & win_hit & (tsel == TSEL_W'(g)) & (rsel == 2'd3);
    assign cnt_w[g]   = cnt_reg[g][CNT_W-1:0];

    tmr_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step[g]),
      .expire  (expire[g]),
      .irq_mask(link_out[g]),
      .wr_cnt  (wr_cnt[g]),
      .wr_base (wr_base[g]),
      .wr_vec  (wr_vec[g]),
      .wr_dst  (wr_dst[g]),
      .wdata   (bus_wdata),
      .cnt_reg (cnt_reg[g]),
      .base_reg(base_reg[g]),
      .vec_reg (vec_reg[g]),
      .dst_reg (dst_reg[g]),
      .hold    (hold[g]),
      .irq     (tmr_irq[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= '0;
      roll_q <= '0;
      dsel_q <= '0;
    end else if (bus_wr && ctl_hit) begin
      link_q <= bus_wdata[LINK_W-1:0];
      dsel_q <= bus_wdata[DSEL_LSB +: SEL_W];
      roll_q <= bus_wdata[ROLL_LSB +: LINK_W];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (ctl_hit) begin
      bus_rdata[LINK_W-1:0]          = link_q;
      bus_rdata[DSEL_LSB +: SEL_W]   = dsel_q;
      bus_rdata[ROLL_LSB +: LINK_W]  = roll_q;
    end else if (win_hit) begin
      unique case (rsel)
        2'd0:    bus_rdata = cnt_reg[tsel];
        2'd1:    bus_rdata = base_reg[tsel];
        2'd2:    bus_rdata = vec_reg[tsel];
        default: bus_rdata = dst_reg[tsel];
      endcase
    end
  end
endmodule

// File: rtl/tmr_group_chk.sv
module tmr_group_chk
  import tmr_pkg::*;
#(
  parameter int unsigned N_TMR = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick,
  input logic [N_TMR-1:0]            run,
  input logic [N_TMR-1:0]            expire,
  input logic [N_TMR-2:0]            link_q,
  input logic [N_TMR-1:0]            wr_cnt,
  input logic [N_TMR-1:0]            wr_base,
  input logic [N_TMR-1:0][CNT_W-1:0] cnt_w,
  input logic [N_TMR-1:0]            tmr_irq
);
  assert_tick_spaced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  for (genvar g = 0; g < N_TMR; g++) begin : g_chk
    assert_irq_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_irq[g] |=> !tmr_irq[g]);

    assert_irq_after_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_irq[g] |-> $past(expire[g]));

    assert_hold_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[g] && !wr_cnt[g] && !wr_base[g]) |=> $stable(cnt_w[g]));

    if (g < N_TMR - 1) begin : g_low
      assert_low_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq[g] |-> !$past(link_q[g]));
    end

    if (g > 0) begin : g_up
      assert_upper_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q[g-1] && !expire[g-1] && !wr_cnt[g] && !wr_base[g]) |=> $stable(cnt_w[g]));
    end
  end
endmodule

bind tmr_group tmr_group_chk #(.N_TMR(N_TMR)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .run    (run),
  .expire (expire),
  .link_q (link_q),
  .wr_cnt (wr_cnt),
  .wr_base(wr_base),
  .cnt_w  (cnt_w),
  .tmr_irq(tmr_irq)
);

// File: tb/tmr_group_bench.sv
module tmr_group_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tmr_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit live = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_group u_tmr_group (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq(tmr_irq)
  );

  // ---------------- behavioural reference ----------------
  bit [31:0] m_base [4];
  bit [31:0] m_cnt  [4];
  bit        m_tog  [4];
  bit [31:0] m_vec  [4];
  bit [31:0] m_dst  [4];
  bit        m_irq  [4];
  bit [31:0] m_gcr;
  int        m_pcnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_base[i] = 32'h8000_0000; m_cnt[i] = 0; m_tog[i] = 0;
        m_vec[i] = 0; m_dst[i] = 0; m_irq[i] = 0;
      end
      m_gcr = 0; m_pcnt = 0;
    end else begin
      int  period;
      bit  tk, prev;
      bit  lk_up [4];
      bit  go    [4];
      period = 8 * (2 ** int'(m_gcr[9:8]));
      tk = (m_pcnt >= period - 1);
      m_pcnt = tk ? 0 : m_pcnt + 1;
      lk_up[0] = 0; lk_up[1] = m_gcr[0]; lk_up[2] = m_gcr[1]; lk_up[3] = m_gcr[2];
      go[3] = !m_base[3][31];
      go[2] = m_gcr[2] ? go[3] : !m_base[2][31];
      go[1] = m_gcr[1] ? go[2] : !m_base[1][31];
      go[0] = m_gcr[0] ? go[1] : !m_base[0][31];
      prev = 0;
      for (int i = 0; i < 4; i++) begin
        bit adv, ex;
        adv = go[i] && (lk_up[i] ? prev : tk);
        ex = adv && (m_cnt[i] <= 1);
        m_irq[i] = ex && !m_gcr[i];
        if (ex) begin m_cnt[i] = m_base[i] & 32'h7FFF_FFFF; m_tog[i] = !m_tog[i]; end
        else if (adv) m_cnt[i] = m_cnt[i] - 1;
        prev = ex;
      end
      if (bus_wr) begin
        if (bus_addr == 9'h100) m_gcr = bus_wdata & 32'h0700_0307;
        else if (bus_addr < 9'h100 && bus_addr[3:0] == 0) begin
          int t, r;
          t = int'(bus_addr[7:6]); r = int'(bus_addr[5:4]);
          case (r)
            0: begin m_cnt[t] = bus_wdata & 32'h7FFF_FFFF; m_tog[t] = bus_wdata[31]; end
            1: begin
              if (m_base[t][31] || bus_wdata[31]) m_cnt[t] = bus_wdata & 32'h7FFF_FFFF;
              m_base[t] = bus_wdata;
            end
            2: m_vec[t] = bus_wdata;
            default: m_dst[t] = bus_wdata;
          endcase
        end
      end
    end
  end

  function automatic bit [31:0] mread(input bit [8:0] a);
    int t, r;
    if (a == 9'h100) return m_gcr;
    if (a >= 9'h100 || a[3:0] != 0) return 0;
    t = int'(a[7:6]); r = int'(a[5:4]);
    case (r)
      0: return {m_tog[t], m_cnt[t][30:0]};
      1: return m_base[t];
      2: return m_vec[t];
      default: return m_dst[t];
    endcase
  endfunction

  // ---------------- checking ----------------
  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  // interrupts compared against the model on every clock (R6, R8)
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (live && rst_n) begin
      for (int i = 0; i < 4; i++)
        check(m_gcr[i] ? "R8 irq of linked lower timer" : "R6 irq pulse",
              32'(tmr_irq[i]), 32'(m_irq[i]));
    end
  end

  task automatic wr(input bit [8:0] a, input bit [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_exp(input bit [8:0] a, input bit [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic rd_mod(input bit [8:0] a, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, mread(a));
  endtask

  task automatic count_irq(input int idx, input int cycles, output int pulses);
    pulses = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (tmr_irq[idx]) pulses++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;

    // R1: reset state
    for (int t = 0; t < 4; t++) begin
      rd_exp(9'(t * 64 + 16), 32'h8000_0000, "R1 base after reset");
      rd_exp(9'(t * 64),      32'h0,         "R1 count after reset");
      rd_exp(9'(t * 64 + 32), 32'h0,         "R1 routing after reset");
    end
    rd_exp(9'h100, 32'h0, "R1 control after reset");
    check("R1 irq after reset", 32'(tmr_irq), 32'h0);

    // R2: routing/destination storage and map
    for (int t = 0; t < 4; t++) begin
      wr(9'(t * 64 + 32), 32'hA5A5_0000 + 32'(t));
      wr(9'(t * 64 + 48), 32'h5A5A_FF00 ^ 32'(t * 3));
    end
    for (int t = 0; t < 4; t++) begin
      rd_exp(9'(t * 64 + 32), 32'hA5A5_0000 + 32'(t), "R2 routing storage");
      rd_exp(9'(t * 64 + 48), 32'h5A5A_FF00 ^ 32'(t * 3), "R2 destination storage");
    end
    wr(9'h104, 32'hFFFF_FFFF);
    wr(9'h014, 32'h1234_5678);
    rd_exp(9'h104, 32'h0, "R2 unmapped read");
    rd_exp(9'h014, 32'h0, "R2 misaligned read");
    rd_exp(9'h1C0, 32'h0, "R2 high unmapped read");
    rd_exp(9'h010, 32'h8000_0000, "R2 stray write left base untouched");
    rd_exp(9'h100, 32'h0, "R2 stray write left control untouched");

    // R9: control field storage
    wr(9'h100, 32'hFFFF_FFF8);
    rd_exp(9'h100, 32'h0700_0300, "R9 control keeps only defined fields");
    wr(9'h100, 32'h0);

    // R5: base write while held presets the count
    wr(9'h0D0, 32'h8000_0005);
    rd_exp(9'h0C0, 32'h0000_0005, "R5 preset from held base write");
    wr(9'h0C0, 32'h8000_0000);
    rd_exp(9'h0C0, 32'h8000_0000, "R7 count write sets toggle and count");
    wr(9'h0D0, 32'h8000_0005);
    rd_exp(9'h0C0, 32'h8000_0005, "R5 preset leaves toggle unchanged");
    wr(9'h0C0, 32'h0);
    rd_exp(9'h0C0, 32'h0, "R7 zero write clears count word");

    // R4: held timer does not move
    repeat (100) @(negedge clk);
    rd_exp(9'h0C0, 32'h0, "R4 held timer count unchanged");

    // R6/R3: start timer 3 with period 5 ticks at divide by 8
    wr(9'h0D0, 32'h0000_0005);
    rd_exp(9'h0C0, 32'h0000_0005, "R5 release loads base value");
    repeat (20) @(negedge clk);
    count_irq(3, 400, p);
    check("R3 R6 pulses at divide by 8", 32'(p), 32'd10);
    rd_mod(9'h0C0, "R6 count and toggle track reload");

    // R3: divide by 64
    wr(9'h100, 32'h0000_0300);
    repeat (400) @(negedge clk);
    count_irq(3, 3200, p);
    check("R3 pulses at divide by 64", 32'(p), 32'd10);
    rd_mod(9'h0C0, "R6 count mid period");

    // R4: stop again and hold
    wr(9'h0D0, 32'h8000_0007);
    repeat (300) @(negedge clk);
    rd_exp(9'h0C0, {mread(9'h0C0)}, "R4 model agrees on held word");
    check("R4 held count field", mread(9'h0C0) & 32'h7FFF_FFFF, 32'h7);
    wr(9'h100, 32'h0);

    // R8: link timers 0 and 1; lower's own hold flag clear
    wr(9'h100, 32'h0100_0001);
    rd_exp(9'h100, 32'h0100_0001, "R9 link and rollover stored");
    wr(9'h050, 32'h8000_0002);
    wr(9'h010, 32'h0000_0003);
    repeat (200) @(negedge clk);
    rd_exp(9'h000, 32'h0000_0003, "R8 lower held by upper's hold flag");
    wr(9'h050, 32'h0000_0002);
    repeat (30) @(negedge clk);
    count_irq(0, 480, p);
    check("R8 lower timer never pulses", 32'(p), 32'd0);
    count_irq(1, 480, p);
    check("R8 pair period is product of bases", 32'(p), 32'd10);
    rd_mod(9'h000, "R8 lower count");
    rd_mod(9'h040, "R8 upper count");

    // three-timer chain
    wr(9'h100, 32'h0000_0003);
    wr(9'h090, 32'h0000_0002);
    repeat (600) @(negedge clk);
    rd_mod(9'h080, "R8 chain top count");
    rd_mod(9'h040, "R8 chain middle count");
    wr(9'h090, 32'h8000_0002);
    wr(9'h100, 32'h0);
    wr(9'h050, 32'h8000_0000);
    wr(9'h010, 32'h8000_0000);

    // R10: writes colliding with steps on timer 2
    wr(9'h090, 32'h0000_0004);
    for (int k = 0; k < 30; k++) begin
      wr(9'h080, 32'(k % 3));
      if (k % 5 == 4) rd_mod(9'h080, "R10 write precedence over step");
    end
    for (int k = 0; k < 12; k++) begin
      wr(9'h090, 32'(2 + k % 3));
      rd_mod(9'h080, "R10 base write against running timer");
    end
    wr(9'h090, 32'h8000_0000);

    // R6: full-width base value
    wr(9'h0D0, 32'hFFFF_FFFF);
    rd_mod(9'h0C0, "R6 count field excludes toggle bit");
    repeat (5) @(negedge clk);

    live = 0;
    finish_run();
  end
endmodule